// File: doc/BRIEF.md
# Complementary PWM Output Channel

This block is one output-compare channel of a timer. A free-running counter, a compare value and a 3-bit compare-mode field come in. From them the block builds an internal reference level. That level can follow set, clear or toggle on a match, two PWM shapes, or two forced levels. It is held in a register that the counter advances every cycle.

The reference is then steered onto a main pin and a complementary pin. A truth table makes the choice for each pin. Its inputs are a master output enable, a run-state select, an idle-state select, the per-pin enables, the per-pin polarities and the per-pin idle levels. The table decides whether a pin is driven low with its driver off, held at its polarity level, held at its idle level, or driven from the reference.

The compare mode and both polarities are kept in shadow registers. These load only on an update event, so a change written in the middle of a period never shows up part-way through it. Each pin value and each driver-enable leaves the block from a flop. A counter value sampled at one clock edge therefore reaches the pins two edges later.

Top module: `cpwm_channel`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, out_main, oe_main, out_comp and oe_comp are all 0.
- R2: Shadow mode 4 makes the reference 0 and shadow mode 5 makes it 1, whatever the counter and compare values are.
- R3: Shadow mode 6 makes the reference 1 when cnt < cmp_val and 0 otherwise. Shadow mode 7 gives the inverse.
- R4: When cnt == cmp_val, shadow mode 1 sets the reference, mode 2 clears it and mode 3 toggles it. Off a match these modes hold the reference, and mode 0 always holds it.
- R5: With moe=0 and idle_sel=0, both pins go to 0 and both driver enables go to 0, whatever the pin enables are.
- R6: With moe=0 and idle_sel=1, out_main is idle_main and out_comp is idle_comp. Each driver enable then equals that pin's own enable.
- R7: With moe=1, en_main=1 and en_comp=0 (run_sel=0), out_main is ref XOR main polarity with oe_main=1, and out_comp=0 with oe_comp=0.
- R8: With moe=1, en_main=0 and en_comp=1 (run_sel=0), out_main=0 with oe_main=0, and out_comp is ref XOR comp polarity with oe_comp=1.
- R9: With moe=1 and both pin enables set, out_main is ref XOR main polarity and out_comp is (NOT ref) XOR comp polarity, and both driver enables are 1.
- R10: With moe=1 and run_sel=1, a pin whose enable is 0 is driven at its own polarity level with its driver enable at 1.
- R11: The mode and polarity inputs take effect only through an update event. The shadow copies change only at a clock edge where upd_evt=1.
- R12: With moe=1 and both pin enables set, the two pins are never active together, a pin being active when its level differs from its polarity.
- R13: All pin outputs are registered. A counter or compare change seen at one edge reaches the pins two edges later, and a control input change reaches them one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | CNT_W | Counter value |
| cmp_val | input | CNT_W | Compare value |
| cmp_mode | input | 3 | Compare mode, loaded into the shadow register on update |
| pol_main | input | 1 | Main pin polarity, loaded on update |
| pol_comp | input | 1 | Complementary pin polarity, loaded on update |
| upd_evt | input | 1 | Counter update event, loads the shadow registers |
| moe | input | 1 | Master output enable |
| run_sel | input | 1 | Run-state select for disabled pins while moe=1 |
| idle_sel | input | 1 | Idle-state select while moe=0 |
| en_main | input | 1 | Main pin enable |
| en_comp | input | 1 | Complementary pin enable |
| idle_main | input | 1 | Main pin idle level |
| idle_comp | input | 1 | Complementary pin idle level |
| out_main | output | 1 | Main pin level |
| oe_main | output | 1 | Main pin driver enable |
| out_comp | output | 1 | Complementary pin level |
| oe_comp | output | 1 | Complementary pin driver enable |

## Verification
In the same cycle, a counter match can advance the reference while an update event swaps the shadow mode and polarities. The bench provokes this by raising upd_evt at the edge where cnt equals cmp_val, and by changing cmp_mode without an update in the middle of a sweep. A cycle-level model in the bench applies the old shadow to the match and the new shadow from the next edge on. Each pin output is judged against that model, so a design that lets the new mode or polarity act one edge early, or lets it act without an update, shows a miscompare.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

   typedef enum logic [2:0] {
      CM_HOLD  = 3'd0,
      CM_SET   = 3'd1,
      CM_CLR   = 3'd2,
      CM_TGL   = 3'd3,
      CM_LOW   = 3'd4,
      CM_HIGH  = 3'd5,
      CM_PWM_A = 3'd6,
      CM_PWM_B = 3'd7
   } cmp_mode_e;

   localparam int unsigned PIN_N    = 2;
   localparam int unsigned PIN_MAIN = 0;
   localparam int unsigned PIN_COMP = 1;

   typedef struct packed {
      logic [2:0] mode;
      logic [PIN_N-1:0] pol;
   } shadow_t;

endpackage

// File: rtl/cpwm_shadow.sv
module cpwm_shadow
   import cpwm_pkg::*;
#(
   parameter int unsigned W = $bits(shadow_t)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("cpwm_shadow: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end

endmodule

// File: rtl/cpwm_refgen.sv
module cpwm_refgen
   import cpwm_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [2:0]       mode,
   output logic             ref_q
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("cpwm_refgen: CNT_W must be at least 2");
   end

   logic hit;
   logic below;
   logic ref_d;

   assign hit   = (cnt == cmp_val);
   assign below = (cnt < cmp_val);

   always_comb begin
      ref_d = ref_q;
      unique case (cmp_mode_e'(mode))
         CM_HOLD:  ref_d = ref_q;
         CM_SET:   if (hit) ref_d = 1'b1;
         CM_CLR:   if (hit) ref_d = 1'b0;
         CM_TGL:   if (hit) ref_d = ~ref_q;
         CM_LOW:   ref_d = 1'b0;
         CM_HIGH:  ref_d = 1'b1;
         CM_PWM_A: ref_d = below;
         CM_PWM_B: ref_d = ~below;
         default:  ref_d = ref_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ref_q <= 1'b0;
      else
         ref_q <= ref_d;
   end

endmodule

// File: rtl/cpwm_outstage.sv
module cpwm_outstage
   import cpwm_pkg::*;
#(
   parameter int unsigned NP = PIN_N
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ref_lvl,
   input  logic          moe,
   input  logic          run_sel,
   input  logic          idle_sel,
   input  logic [NP-1:0] en,
   input  logic [NP-1:0] pol,
   input  logic [NP-1:0] idle,
   output logic [NP-1:0] pin,
   output logic [NP-1:0] oe
);

   if (NP != 2) begin : g_bad_np
      $error("cpwm_outstage: NP must be 2 (main and complementary)");
   end

   logic [NP-1:0] src;

   // main follows the reference; complementary inverts it only when paired
   assign src[PIN_MAIN] = ref_lvl;
   assign src[PIN_COMP] = en[PIN_MAIN] ? ~ref_lvl : ref_lvl;

   for (genvar i = 0; i < NP; i++) begin : g_pin
      logic val_d;
      logic oe_d;

      always_comb begin
         val_d = 1'b0;
         oe_d  = 1'b0;
         if (!moe) begin
            if (idle_sel) begin
               val_d = idle[i];
               oe_d  = en[i];
            end
         end else if (en[i]) begin
            val_d = src[i] ^ pol[i];
            oe_d  = 1'b1;
         end else if (run_sel) begin
            val_d = pol[i];
            oe_d  = 1'b1;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pin[i] <= 1'b0;
            oe[i]  <= 1'b0;
         end else begin
            pin[i] <= val_d;
            oe[i]  <= oe_d;
         end
      end
   end

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
   import cpwm_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [2:0]       cmp_mode,
   input  logic             pol_main,
   input  logic             pol_comp,
   input  logic             upd_evt,
   input  logic             moe,
   input  logic             run_sel,
   input  logic             idle_sel,
   input  logic             en_main,
   input  logic             en_comp,
   input  logic             idle_main,
   input  logic             idle_comp,
   output logic             out_main,
   output logic             oe_main,
   output logic             out_comp,
   output logic             oe_comp
);

   localparam int unsigned SH_W = $bits(shadow_t);

   shadow_t          sh_d;
   shadow_t          sh_q;
   logic [2:0]       mode_s;
   logic [PIN_N-1:0] pol_s;
   logic             ref_q;
   logic [PIN_N-1:0] pin;
   logic [PIN_N-1:0] oe;

   assign sh_d.mode = cmp_mode;
   assign sh_d.pol  = {pol_comp, pol_main};

   cpwm_shadow #(.W(SH_W)) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (upd_evt),
      .d     (sh_d),
      .q     (sh_q)
   );

   assign mode_s = sh_q.mode;
   assign pol_s  = sh_q.pol;

   cpwm_refgen #(.CNT_W(CNT_W)) u_ref (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (cnt),
      .cmp_val (cmp_val),
      .mode    (mode_s),
      .ref_q   (ref_q)
   );

   cpwm_outstage #(.NP(PIN_N)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_lvl  (ref_q),
      .moe      (moe),
      .run_sel  (run_sel),
      .idle_sel (idle_sel),
      .en       ({en_comp, en_main}),
      .pol      (pol_s),
      .idle     ({idle_comp, idle_main}),
      .pin      (pin),
      .oe       (oe)
   );

   assign out_main = pin[PIN_MAIN];
   assign oe_main  = oe[PIN_MAIN];
   assign out_comp = pin[PIN_COMP];
   assign oe_comp  = oe[PIN_COMP];

endmodule

// File: rtl/cpwm_channel_chk.sv
module cpwm_channel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       upd_evt,
   input logic       moe,
   input logic       idle_sel,
   input logic       en_main,
   input logic       en_comp,
   input logic       idle_main,
   input logic       idle_comp,
   input logic [2:0] cmp_mode,
   input logic [2:0] mode_s,
   input logic [1:0] pol_s,
   input logic       ref_q,
   input logic       out_main,
   input logic       oe_main,
   input logic       out_comp,
   input logic       oe_comp
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_main && !oe_main && !out_comp && !oe_comp));

   // R2
   force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_s == 3'd4) |=> !ref_q);

   // R2
   force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_s == 3'd5) |=> ref_q);

   // R5
   parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!moe && !idle_sel) |=> (!out_main && !oe_main && !out_comp && !oe_comp));

   // R6
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!moe && idle_sel) |=> (out_main == $past(idle_main) && out_comp == $past(idle_comp)
                               && oe_main == $past(en_main) && oe_comp == $past(en_comp)));

   // R11
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_evt |=> $stable(mode_s) && $stable(pol_s));

   // R11
   shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_evt |=> (mode_s == $past(cmp_mode)));

   // R12
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (moe && en_main && en_comp) |=>
         !((out_main ^ $past(pol_s[0])) && (out_comp ^ $past(pol_s[1]))));

endmodule

bind cpwm_channel cpwm_channel_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .upd_evt   (upd_evt),
   .moe       (moe),
   .idle_sel  (idle_sel),
   .en_main   (en_main),
   .en_comp   (en_comp),
   .idle_main (idle_main),
   .idle_comp (idle_comp),
   .cmp_mode  (cmp_mode),
   .mode_s    (mode_s),
   .pol_s     (pol_s),
   .ref_q     (ref_q),
   .out_main  (out_main),
   .oe_main   (oe_main),
   .out_comp  (out_comp),
   .oe_comp   (oe_comp)
);

// File: tb/sim_cpwm_channel.sv
`timescale 1ns/1ps
module sim_cpwm_channel;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] cnt = '0, cmp_val = '0;
   logic [2:0]   cmp_mode = '0;
   logic         pol_main = 0, pol_comp = 0, upd_evt = 0;
   logic         moe = 0, run_sel = 0, idle_sel = 0;
   logic         en_main = 0, en_comp = 0, idle_main = 0, idle_comp = 0;
   logic         out_main, oe_main, out_comp, oe_comp;

   always #4 clk = ~clk;

   cpwm_channel #(.CNT_W(W)) u0 (.*);

   typedef struct {
      logic [3:0] exp;
      string      tag;
   } item_t;

   item_t q[$];
   int    vecs = 0;
   int    bad  = 0;
   bit    done = 0;
   string tag  = "R5";

   logic       m_ref = 0;
   logic [2:0] m_mode = 0;
   logic       m_pm = 0, m_pc = 0;

   function automatic logic nref(logic r, logic [2:0] md, logic [W-1:0] c, logic [W-1:0] k);
      case (md)
         3'd1: return (c == k) ? 1'b1 : r;
         3'd2: return (c == k) ? 1'b0 : r;
         3'd3: return (c == k) ? ~r : r;
         3'd4: return 1'b0;
         3'd5: return 1'b1;
         3'd6: return c < k;
         3'd7: return !(c < k);
         default: return r;
      endcase
   endfunction

   // returns {value, oe}
   function automatic logic [1:0] pinf(logic en, logic src, logic pol, logic idl);
      if (!moe) return idle_sel ? {idl, en} : 2'b00;
      if (en) return {src ^ pol, 1'b1};
      if (run_sel) return {pol, 1'b1};
      return 2'b00;
   endfunction

   task automatic tick();
      item_t it;
      @(posedge clk);
      it.exp = {pinf(en_main, m_ref, m_pm, idle_main),
                pinf(en_comp, en_main ? ~m_ref : m_ref, m_pc, idle_comp)};
      it.tag = tag;
      q.push_back(it);
      m_ref = nref(m_ref, m_mode, cnt, cmp_val);
      if (upd_evt) begin
         m_mode = cmp_mode;
         m_pm = pol_main;
         m_pc = pol_comp;
      end
      @(negedge clk);
   endtask

   task automatic sweep(int from, int to);
      for (int i = from; i <= to; i++) begin
         cnt = W'(i);
         tick();
      end
   endtask

   task automatic load(logic [2:0] md, logic pm, logic pc);
      cmp_mode = md; pol_main = pm; pol_comp = pc; upd_evt = 1;
      tick();
      upd_evt = 0;
   endtask

   // monitor
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         logic [3:0] act;
         it = q.pop_front();
         act = {out_main, oe_main, out_comp, oe_comp};
         vecs++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s: {out_main,oe_main,out_comp,oe_comp} = %b expected %b at %0t",
                     it.tag, act, it.exp, $time);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      // R1: outputs quiet during reset, even with controls asking to drive
      moe = 1; run_sel = 1; en_main = 1; en_comp = 1;
      repeat (3) @(negedge clk);
      vecs++;
      if ({out_main, oe_main, out_comp, oe_comp} !== 4'b0000) begin
         bad++;
         $display("FAIL R1: outputs %b expected 0000", {out_main, oe_main, out_comp, oe_comp});
      end
      moe = 0; run_sel = 0; en_main = 0; en_comp = 0;
      rst_n = 1;

      // R5: parked low whatever the pin enables
      tag = "R5"; tick();
      en_main = 1; en_comp = 1; tick(); tick();
      en_main = 0; en_comp = 0;

      // R3 + R7 + R13: PWM mode 6, main only
      tag = "R3_R7"; cmp_val = 5;
      load(3'd6, 1'b0, 1'b0);
      moe = 1; en_main = 1;
      sweep(0, 9);
      tag = "R3_pwmB"; load(3'd7, 1'b1, 1'b0);
      sweep(0, 9);

      // R11: mode/polarity change without update has no effect
      tag = "R11"; cmp_mode = 3'd5; pol_main = 0; pol_comp = 1;
      sweep(0, 9);

      // R2: forced levels, counter swept across the compare value
      tag = "R2"; load(3'd4, 1'b0, 1'b0);
      sweep(3, 7);
      load(3'd5, 1'b0, 1'b0);
      sweep(3, 7);

      // R8: complementary only
      tag = "R8"; en_main = 0; en_comp = 1;
      load(3'd6, 1'b0, 1'b1);
      sweep(0, 8);

      // R4: match modes, update coinciding with a match
      tag = "R4"; en_main = 1; en_comp = 0; cmp_val = 4;
      cnt = 4; load(3'd2, 1'b0, 1'b0);
      sweep(2, 6);
      cnt = 4; load(3'd1, 1'b0, 1'b0);
      sweep(2, 6);
      load(3'd3, 1'b0, 1'b0);
      cnt = 4; tick(); tick(); tick();
      sweep(5, 7);
      load(3'd0, 1'b0, 1'b0);
      cnt = 4; tick(); tick();

      // R9 + R12: both pins, several polarity sets
      tag = "R9_R12"; en_main = 1; en_comp = 1; cmp_val = 3;
      load(3'd6, 1'b0, 1'b0); sweep(0, 6);
      load(3'd6, 1'b1, 1'b0); sweep(0, 6);
      load(3'd7, 1'b1, 1'b1); sweep(0, 6);

      // R10: run-state select on disabled pins
      tag = "R10"; run_sel = 1; en_main = 0; en_comp = 0;
      load(3'd6, 1'b1, 1'b0); sweep(0, 5);
      en_main = 1; sweep(0, 5);
      en_main = 0; en_comp = 1; sweep(0, 5);
      run_sel = 0;

      // R6: idle levels with master enable off
      tag = "R6"; moe = 0; idle_sel = 1;
      for (int k = 0; k < 16; k++) begin
         {idle_main, idle_comp, en_main, en_comp} = 4'(k);
         tick();
      end
      tag = "R5"; idle_sel = 0; tick(); tick();

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule